// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block holds the interrupt capture logic for a row of GPIO pins. For each pin it watches the pin level, which has already been debounced and synchronised. It decides each cycle whether the pin's configured trigger condition is met. A hit is recorded in a sticky interrupt status bit and in a sticky wake status bit. Each status bit then stays set until software clears it.

Per pin, software supplies the following:
- an interrupt-enable bit, which gates capture into the interrupt status;
- a wake-enable bit, which gates capture into the wake status;
- a delivery mask, where 1 lets the request through;
- a trigger-style bit, where 1 means level and 0 means edge;
- a 2-bit polarity code.

A one-cycle clear strobe per pin erases both status bits. Each pin presents a pending flag, set when either status bit is set, and an interrupt request, which is the interrupt status passed through the delivery mask.

Top module: `gpio_evt_detect`

## Requirements
- R1: While reset is asserted, and on the first sampling edge after it, every status, pending and request output is 0.
- R2: In edge mode, polarity code 01 sets the interrupt status on the clock edge that first samples the pin high after it was low. A falling edge does not set it.
- R3: In edge mode, polarity code 00 sets the interrupt status on the clock edge that first samples the pin low after it was high. A rising edge does not set it.
- R4: In edge mode, polarity code 10 sets the interrupt status on either a rising or a falling edge.
- R5: In level mode, code 01 detects on every edge that samples the pin high, and code 00 detects on every edge that samples it low. So the status sets again right after a clear while the level persists. Code 10 in level mode detects nothing.
- R6: Polarity code 11 never sets either status bit, in either mode.
- R7: While the interrupt-enable bit is 0, the interrupt status takes no new events and keeps its current value unless cleared.
- R8: A 1 on the clear strobe resets both status bits of that pin on the next edge. If a detection for a status bit happens on the same edge, that detection wins and the bit stays set.
- R9: The wake status is set by a detection while the wake-enable bit is 1, independently of the interrupt-enable bit.
- R10: The pending output is the OR of the two status bits. The request output is the interrupt status AND the mask bit, so a set wake status alone never raises a request.
- R11: The first clock edge after reset release records the pin level without ever treating it as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pinLvl | input | NP | Debounced, synchronous pin levels |
| intEn | input | NP | Interrupt capture enable per pin |
| wakeEn | input | NP | Wake capture enable per pin |
| unmask | input | NP | Delivery mask per pin, 1 = request delivered |
| lvlTrig | input | NP | Trigger style per pin, 1 = level, 0 = edge |
| actCode | input | 2*NP | Polarity code, bits [2i+1:2i] for pin i: 00 low/falling, 01 high/rising, 10 both edges, 11 off |
| clrSts | input | NP | Write-one-to-clear strobe for both status bits |
| intSts | output | NP | Sticky interrupt status |
| wakeSts | output | NP | Sticky wake status |
| pending | output | NP | Either status bit set |
| irq | output | NP | Interrupt request to the controller |

## Verification
The assertions assume the following about the inputs:
- every input is synchronous to the clock and stable across each rising edge;
- the pin level needs no further filtering;
- the configuration may change on any cycle, since every property is phrased for a single edge.

The stimulus meets these assumptions by driving every input on the falling clock edge only. Random draws cover all four polarity codes, including the unused one, both trigger styles, and clear strobes that collide with detections.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_OFF  = 2'b11
  } polCodeT;

  // Per-pin strobes from control to datapath
  typedef struct packed {
    logic intSet;
    logic wakeSet;
    logic clr;
  } stbT;

endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NP-1:0]        pinLvl,
  input  logic [NP-1:0]        intEn,
  input  logic [NP-1:0]        wakeEn,
  input  logic [NP-1:0]        lvlTrig,
  input  logic [2*NP-1:0]      actCode,
  input  logic [NP-1:0]        clrSts,
  output stbT  [NP-1:0]        stb
);

  logic [NP-1:0] prevLvl;
  logic          armed;

  // History of the pin level; armed blocks a false edge right after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= '0;
      armed   <= 1'b0;
    end else begin
      prevLvl <= pinLvl;
      armed   <= 1'b1;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : gPin
    polCodeT pol;
    logic    rise, fall, hit;

    assign pol  = polCodeT'(actCode[2*i +: 2]);
    assign rise = armed & ~prevLvl[i] &  pinLvl[i];
    assign fall = armed &  prevLvl[i] & ~pinLvl[i];

    always_comb begin
      hit = 1'b0;
      if (lvlTrig[i]) begin
        case (pol)
          POL_LOW:  hit = ~pinLvl[i];
          POL_HIGH: hit =  pinLvl[i];
          default:  hit = 1'b0;
        endcase
      end else begin
        case (pol)
          POL_LOW:  hit = fall;
          POL_HIGH: hit = rise;
          POL_BOTH: hit = rise | fall;
          default:  hit = 1'b0;
        endcase
      end
    end

    assign stb[i].intSet  = hit & intEn[i];
    assign stb[i].wakeSet = hit & wakeEn[i];
    assign stb[i].clr     = clrSts[i];
  end

endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  stbT  [NP-1:0] stb,
  input  logic [NP-1:0] unmask,
  output logic [NP-1:0] intSts,
  output logic [NP-1:0] wakeSts,
  output logic [NP-1:0] pending,
  output logic [NP-1:0] irq
);

  for (genvar i = 0; i < NP; i++) begin : gBit
    // Set has priority over clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intSts[i]  <= 1'b0;
        wakeSts[i] <= 1'b0;
      end else begin
        if (stb[i].intSet)   intSts[i] <= 1'b1;
        else if (stb[i].clr) intSts[i] <= 1'b0;
        if (stb[i].wakeSet)  wakeSts[i] <= 1'b1;
        else if (stb[i].clr) wakeSts[i] <= 1'b0;
      end
    end
  end

  assign pending = intSts | wakeSts;
  assign irq     = intSts & unmask;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NP-1:0]     pinLvl,
  input  logic [NP-1:0]     intEn,
  input  logic [NP-1:0]     wakeEn,
  input  logic [NP-1:0]     unmask,
  input  logic [NP-1:0]     lvlTrig,
  input  logic [2*NP-1:0]   actCode,
  input  logic [NP-1:0]     clrSts,
  output logic [NP-1:0]     intSts,
  output logic [NP-1:0]     wakeSts,
  output logic [NP-1:0]     pending,
  output logic [NP-1:0]     irq
);

  stbT [NP-1:0] stb;

  gpio_evt_ctrl #(.NP(NP)) uCtrl (
    .clk(clk), .rstN(rstN), .pinLvl(pinLvl), .intEn(intEn), .wakeEn(wakeEn),
    .lvlTrig(lvlTrig), .actCode(actCode), .clrSts(clrSts), .stb(stb)
  );

  gpio_evt_dp #(.NP(NP)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .unmask(unmask),
    .intSts(intSts), .wakeSts(wakeSts), .pending(pending), .irq(irq)
  );

endmodule

// File: rtl/gpio_evt_detect_chk.sv
module gpio_evt_detect_chk #(
  parameter int NP = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [NP-1:0]   pinLvl,
  input logic [NP-1:0]   intEn,
  input logic [NP-1:0]   wakeEn,
  input logic [NP-1:0]   unmask,
  input logic [NP-1:0]   lvlTrig,
  input logic [2*NP-1:0] actCode,
  input logic [NP-1:0]   clrSts,
  input logic [NP-1:0]   intSts,
  input logic [NP-1:0]   wakeSts,
  input logic [NP-1:0]   pending,
  input logic [NP-1:0]   irq
);

  for (genvar i = 0; i < NP; i++) begin : gChk
    a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
      (!intEn[i] && !clrSts[i]) |=> (intSts[i] == $past(intSts[i])));

    a_r8_clear_wins_without_event: assert property (@(posedge clk) disable iff (!rstN)
      (clrSts[i] && !intEn[i] && !wakeEn[i]) |=> (!intSts[i] && !wakeSts[i]));

    a_r5_level_high_persists: assert property (@(posedge clk) disable iff (!rstN)
      (intEn[i] && lvlTrig[i] && actCode[2*i +: 2] == 2'b01 && pinLvl[i]) |=> intSts[i]);

    a_r6_code_off_silent: assert property (@(posedge clk) disable iff (!rstN)
      (actCode[2*i +: 2] == 2'b11 && clrSts[i]) |=> (!intSts[i] && !wakeSts[i]));

    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
      !unmask[i] |-> !irq[i]);

    a_r10_wake_no_irq: assert property (@(posedge clk) disable iff (!rstN)
      (wakeSts[i] && !intSts[i]) |-> (pending[i] && !irq[i]));
  end

endmodule

bind gpio_evt_detect gpio_evt_detect_chk #(.NP(NP)) uChk (
  .clk(clk), .rstN(rstN), .pinLvl(pinLvl), .intEn(intEn), .wakeEn(wakeEn),
  .unmask(unmask), .lvlTrig(lvlTrig), .actCode(actCode), .clrSts(clrSts),
  .intSts(intSts), .wakeSts(wakeSts), .pending(pending), .irq(irq)
);

// File: tb/gpio_evt_detect_test.sv
`timescale 1ns/1ps
module gpio_evt_detect_test;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinLvl = '0, intEn = '0, wakeEn = '0, unmask = '0, lvlTrig = '0, clrSts = '0;
  logic [2*NP-1:0] actCode = '0;
  logic [NP-1:0] intSts, wakeSts, pending, irq;

  logic [NP-1:0] mPrev = '0, mInt = '0, mWake = '0;
  logic          mArmed = 1'b0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_evt_detect #(.NP(NP)) uut (
    .clk(clk), .rstN(rstN), .pinLvl(pinLvl), .intEn(intEn), .wakeEn(wakeEn),
    .unmask(unmask), .lvlTrig(lvlTrig), .actCode(actCode), .clrSts(clrSts),
    .intSts(intSts), .wakeSts(wakeSts), .pending(pending), .irq(irq)
  );

  // Expected detection from the requirement text
  function automatic logic hitOf(logic [1:0] c, logic trig, logic p, logic pv, logic arm);
    if (trig) return (c == 2'b00 && !p) || (c == 2'b01 && p);
    if (!arm) return 1'b0;
    case (c)
      2'b00:   return pv && !p;
      2'b01:   return !pv && p;
      2'b10:   return pv != p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "intSts", intSts, mInt);
    chk(tag, "wakeSts", wakeSts, mWake);
    chk(tag, "pending", pending, mInt | mWake);
    chk(tag, "irq", irq, mInt & unmask);
  endtask

  // Inputs are already set (at a falling edge); advance one cycle and compare
  task automatic step(string tag);
    logic [NP-1:0] nInt, nWake;
    for (int i = 0; i < NP; i++) begin
      logic e;
      e = hitOf(actCode[2*i +: 2], lvlTrig[i], pinLvl[i], mPrev[i], mArmed);
      nInt[i]  = (e && intEn[i])  ? 1'b1 : (clrSts[i] ? 1'b0 : mInt[i]);
      nWake[i] = (e && wakeEn[i]) ? 1'b1 : (clrSts[i] ? 1'b0 : mWake[i]);
    end
    @(posedge clk);
    mInt = nInt; mWake = nWake; mPrev = pinLvl; mArmed = 1'b1;
    @(negedge clk);
    compareAll(tag);
    clrSts = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: pin 0 high through reset, rising-edge config already active
    pinLvl = 4'b0001; intEn = '1; unmask = '1; actCode = {4{2'b01}};
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step("R11");
    step("R1");

    // R2: rising edge detection, falling ignored
    clrSts = '1; step("R8");
    pinLvl = 4'b1111; step("R2");
    clrSts = '1; step("R8");
    pinLvl = 4'b0000; step("R2");

    // R3: falling edge
    actCode = {4{2'b00}};
    pinLvl = 4'b1010; step("R3");
    pinLvl = 4'b0000; step("R3");
    clrSts = '1; step("R3");

    // R4: both edges
    actCode = {4{2'b10}};
    pinLvl = 4'b0101; step("R4");
    clrSts = '1; pinLvl = 4'b0000; step("R4");
    clrSts = '1; step("R4");

    // R5: level mode, re-assert after clear; code 10 level is silent
    lvlTrig = '1; actCode = {2'b00, 2'b01, 2'b00, 2'b01};
    pinLvl = 4'b0011; step("R5");
    clrSts = '1; step("R5");
    actCode = {4{2'b10}}; clrSts = '1; step("R5");

    // R6: code 11 in both modes
    actCode = {4{2'b11}};
    pinLvl = 4'b1100; step("R6");
    lvlTrig = '0; pinLvl = 4'b0011; step("R6");

    // R7: capture disabled
    intEn = '0; actCode = {4{2'b10}};
    pinLvl = 4'b1111; step("R7");
    intEn = 4'b0001; pinLvl = 4'b0000; step("R7");

    // R9: wake capture independent of interrupt enable
    intEn = '0; wakeEn = '1; clrSts = '1; step("R9");
    pinLvl = 4'b1001; step("R9");

    // R10: mask gates delivery only
    intEn = '1; unmask = 4'b0101; pinLvl = 4'b0110; step("R10");
    unmask = 4'b1010; step("R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      pinLvl  = pinLvl ^ (r[3:0] & r[7:4]);
      intEn   = r[11:8] | r[23:20];
      wakeEn  = r[15:12] & r[27:24];
      unmask  = r[19:16];
      if (r[28]) lvlTrig = r[31:28];
      if (r[29]) actCode = $urandom;
      clrSts  = $urandom & $urandom;
      step("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
  end

endmodule